// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard and Forwarding Controller

This block steers operands and squashes instructions for a single-issue, in-order integer pipeline with three stages: fetch/decode, execute and writeback. Each cycle it takes the decoded register fields and write flags of the instruction in fetch/decode and carries them into its own execute and writeback slots, so an instruction moves one stage per clock. The pipeline never stalls. The only hazard is read-after-write, and the block settles it by forwarding from writeback. For each execute source operand it picks one of three values: the register-file read data, the writeback ALU result, or the writeback load data.

A two-state squash machine handles taken control transfers. Its states are RUN (normal flow) and DRAIN (one more younger instruction still to discard). Transition RUN to DRAIN happens when a valid instruction in execute reports a taken branch or jump. Transition DRAIN to RUN always happens on the next clock. In RUN with a taken branch, and in every DRAIN cycle, the fetch/decode instruction is killed. A killed instruction enters execute as a bubble: its valid bit and write enables are low and it can never be a forwarding source. The register file, ALU, decoder and memories stay outside the block and are seen only as port signals.

Top module: `hz3_ctrl`

## Requirements
- R1: An instruction presented with `fd_valid_i`=1 and `fd_kill_o`=0 shows `ex_valid_o`=1 one clock later and `wb_valid_o`=1 two clocks later. Back-to-back instructions are accepted every cycle with no stall.
- R2: Source 1 forwards the writeback ALU result when all of these hold: writeback is valid, it has the ALU-write flag set and the load flag clear, its destination is not x0, and that destination equals the execute source-1 register. Then `fwd1_sel_o`=1 and `ex_op1_o` equals `wb_alu_data_i`.
- R3: When the writeback instruction has the load flag set and a matching, non-zero destination, the select is 2 and the operand equals `wb_load_data_i`. This holds whether or not the ALU-write flag is also set.
- R4: Source 2 applies the same rule as source 1 on its own. It drives `fwd2_sel_o` and `ex_op2_o` from the execute source-2 register.
- R5: A writeback destination of x0 never forwards. The select stays 0 and the operand is the register-file data.
- R6: When writeback is invalid or has neither write flag, both selects are 0 and `ex_op1_o`/`ex_op2_o` equal `rf_rs1_data_i`/`rf_rs2_data_i`.
- R7: A taken branch in a valid execute instruction raises `fd_kill_o` in that cycle and in the following cycle, and only in those two cycles. The instruction fed in the third cycle runs normally.
- R8: A killed instruction gives `ex_valid_o`=0, `ex_regwr_o`=0 and `ex_memwr_o`=0 in execute. It gives `wb_valid_o`=0 and `wb_regwr_o`=0 in writeback, and it never causes forwarding, even when its destination matches.
- R9: After reset, `ex_valid_o`, `wb_valid_o` and `fd_kill_o` are 0 and both selects are 0.
- R10: `ex_taken_i` has no effect while the execute slot is not valid. In that case `fd_kill_o` stays 0 and the younger instruction proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fd_valid_i | input | 1 | An instruction occupies fetch/decode |
| fd_rs1_i | input | 5 | Source-1 register of the fetch/decode instruction |
| fd_rs2_i | input | 5 | Source-2 register of the fetch/decode instruction |
| fd_rd_i | input | 5 | Destination register of the fetch/decode instruction |
| fd_alu2reg_i | input | 1 | Instruction writes an ALU result to a register |
| fd_mem2reg_i | input | 1 | Instruction writes load data to a register |
| fd_memwr_i | input | 1 | Instruction writes memory |
| ex_taken_i | input | 1 | Execute instruction resolved as a taken branch or jump |
| rf_rs1_data_i | input | 32 | Register-file data for execute source 1 |
| rf_rs2_data_i | input | 32 | Register-file data for execute source 2 |
| wb_alu_data_i | input | 32 | ALU result held in writeback |
| wb_load_data_i | input | 32 | Load data held in writeback |
| ex_valid_o | output | 1 | Execute slot holds a live instruction |
| ex_regwr_o | output | 1 | Register-write enable of the execute instruction |
| ex_memwr_o | output | 1 | Memory-write enable of the execute instruction |
| wb_valid_o | output | 1 | Writeback slot holds a live instruction |
| wb_regwr_o | output | 1 | Register-write enable of the writeback instruction |
| fd_kill_o | output | 1 | Squash the fetch/decode instruction this cycle |
| fwd1_sel_o | output | 2 | Source-1 select: 0 register file, 1 writeback ALU, 2 writeback load |
| fwd2_sel_o | output | 2 | Source-2 select, same encoding |
| ex_op1_o | output | 32 | Selected source-1 operand |
| ex_op2_o | output | 32 | Selected source-2 operand |

## Verification
The hardest case to reach from the ports is a squashed instruction whose destination matches a register that the branch target reads. The killed instruction must reach writeback in exactly the cycle when the target sits in execute. The stimulus sets up a taken branch and feeds two younger instructions, both writing the same register. The target then reads that register, and the bench checks that the source select stays on the register file. Forwarding itself is swept over every destination register, every flag combination and matching and non-matching source pairs. This includes x0 and the case where both write flags are set.

// File: rtl/hz3_pkg.sv
package hz3_pkg;
    localparam int unsigned REG_AW = 5;

    typedef enum logic [1:0] {
        SEL_RF      = 2'd0,
        SEL_WB_ALU  = 2'd1,
        SEL_WB_LOAD = 2'd2
    } opsel_e;

    typedef enum logic {
        SQ_RUN   = 1'b0,
        SQ_DRAIN = 1'b1
    } sq_state_e;

    typedef struct packed {
        logic              vld;
        logic [REG_AW-1:0] rd;
        logic              alu2reg;
        logic              mem2reg;
        logic              memwr;
    } slot_t;
endpackage

// File: rtl/hz3_squash_fsm.sv
module hz3_squash_fsm
    import hz3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ex_vld_i,
    input  logic ex_taken_i,
    output logic kill_o
);
    sq_state_e state_q, state_d;
    logic      redirect;

    assign redirect = ex_vld_i & ex_taken_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_RUN:   if (redirect) state_d = SQ_DRAIN;
            SQ_DRAIN: state_d = SQ_RUN;
            default:  state_d = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        kill_o = 1'b0;
        unique case (state_q)
            SQ_RUN:   kill_o = redirect;
            SQ_DRAIN: kill_o = 1'b1;
            default:  kill_o = 1'b0;
        endcase
    end

    assert_second_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_RUN && redirect) |=> kill_o);
    assert_drain_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_DRAIN) |=> (state_q == SQ_RUN));
endmodule

// File: rtl/hz3_stage_regs.sv
module hz3_stage_regs
    import hz3_pkg::*;
#(
    parameter int unsigned NUM_SRC = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fd_valid_i,
    input  logic                            kill_i,
    input  logic [NUM_SRC-1:0][REG_AW-1:0]  fd_rs_i,
    input  slot_t                           fd_slot_i,
    output slot_t                           ex_slot_o,
    output slot_t                           wb_slot_o,
    output logic [NUM_SRC-1:0][REG_AW-1:0]  ex_rs_o
);
    slot_t accept;
    logic  take;

    assign take = fd_valid_i & ~kill_i;

    always_comb begin
        accept         = fd_slot_i;
        accept.vld     = take;
        accept.alu2reg = fd_slot_i.alu2reg & take;
        accept.mem2reg = fd_slot_i.mem2reg & take;
        accept.memwr   = fd_slot_i.memwr & take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_slot_o <= '0;
            wb_slot_o <= '0;
            ex_rs_o   <= '0;
        end else begin
            ex_slot_o <= accept;
            wb_slot_o <= ex_slot_o;
            ex_rs_o   <= fd_rs_i;
        end
    end

    assert_wb_follows_ex_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ex_slot_o.vld |=> wb_slot_o.vld);
    assert_kill_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (!ex_slot_o.vld && !ex_slot_o.memwr));
endmodule

// File: rtl/hz3_fwd_unit.sv
module hz3_fwd_unit
    import hz3_pkg::*;
#(
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned XLEN    = 32
) (
    input  slot_t                           wb_slot_i,
    input  logic [NUM_SRC-1:0][REG_AW-1:0]  ex_rs_i,
    input  logic [NUM_SRC-1:0][XLEN-1:0]    rf_data_i,
    input  logic [XLEN-1:0]                 wb_alu_i,
    input  logic [XLEN-1:0]                 wb_load_i,
    output opsel_e [NUM_SRC-1:0]            sel_o,
    output logic [NUM_SRC-1:0][XLEN-1:0]    op_o
);
    logic wb_writes;

    assign wb_writes = wb_slot_i.vld && (wb_slot_i.alu2reg || wb_slot_i.mem2reg)
                       && (wb_slot_i.rd != '0);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic hit;
        assign hit = wb_writes && (wb_slot_i.rd == ex_rs_i[s]);

        always_comb begin
            if (!hit)                  sel_o[s] = SEL_RF;
            else if (wb_slot_i.mem2reg) sel_o[s] = SEL_WB_LOAD;
            else                       sel_o[s] = SEL_WB_ALU;
        end

        always_comb begin
            unique case (sel_o[s])
                SEL_WB_ALU:  op_o[s] = wb_alu_i;
                SEL_WB_LOAD: op_o[s] = wb_load_i;
                default:     op_o[s] = rf_data_i[s];
            endcase
        end
    end
endmodule

// File: rtl/hz3_ctrl.sv
module hz3_ctrl
    import hz3_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fd_valid_i,
    input  logic [4:0]        fd_rs1_i,
    input  logic [4:0]        fd_rs2_i,
    input  logic [4:0]        fd_rd_i,
    input  logic              fd_alu2reg_i,
    input  logic              fd_mem2reg_i,
    input  logic              fd_memwr_i,
    input  logic              ex_taken_i,
    input  logic [XLEN-1:0]   rf_rs1_data_i,
    input  logic [XLEN-1:0]   rf_rs2_data_i,
    input  logic [XLEN-1:0]   wb_alu_data_i,
    input  logic [XLEN-1:0]   wb_load_data_i,
    output logic              ex_valid_o,
    output logic              ex_regwr_o,
    output logic              ex_memwr_o,
    output logic              wb_valid_o,
    output logic              wb_regwr_o,
    output logic              fd_kill_o,
    output logic [1:0]        fwd1_sel_o,
    output logic [1:0]        fwd2_sel_o,
    output logic [XLEN-1:0]   ex_op1_o,
    output logic [XLEN-1:0]   ex_op2_o
);
    localparam int unsigned NUM_SRC = 2;

    slot_t                          fd_slot, ex_slot, wb_slot;
    logic [NUM_SRC-1:0][REG_AW-1:0] fd_rs, ex_rs;
    logic [NUM_SRC-1:0][XLEN-1:0]   rf_data, op;
    opsel_e [NUM_SRC-1:0]           sel;
    logic                           kill;

    assign fd_slot = '{vld: fd_valid_i, rd: fd_rd_i, alu2reg: fd_alu2reg_i,
                       mem2reg: fd_mem2reg_i, memwr: fd_memwr_i};
    assign fd_rs   = {fd_rs2_i, fd_rs1_i};
    assign rf_data = {rf_rs2_data_i, rf_rs1_data_i};

    hz3_squash_fsm u_squash (
        .clk        (clk),
        .rst_n      (rst_n),
        .ex_vld_i   (ex_slot.vld),
        .ex_taken_i (ex_taken_i),
        .kill_o     (kill)
    );

    hz3_stage_regs #(.NUM_SRC(NUM_SRC)) u_stages (
        .clk        (clk),
        .rst_n      (rst_n),
        .fd_valid_i (fd_valid_i),
        .kill_i     (kill),
        .fd_rs_i    (fd_rs),
        .fd_slot_i  (fd_slot),
        .ex_slot_o  (ex_slot),
        .wb_slot_o  (wb_slot),
        .ex_rs_o    (ex_rs)
    );

    hz3_fwd_unit #(.NUM_SRC(NUM_SRC), .XLEN(XLEN)) u_fwd (
        .wb_slot_i  (wb_slot),
        .ex_rs_i    (ex_rs),
        .rf_data_i  (rf_data),
        .wb_alu_i   (wb_alu_data_i),
        .wb_load_i  (wb_load_data_i),
        .sel_o      (sel),
        .op_o       (op)
    );

    assign ex_valid_o = ex_slot.vld;
    assign ex_regwr_o = ex_slot.vld & (ex_slot.alu2reg | ex_slot.mem2reg);
    assign ex_memwr_o = ex_slot.vld & ex_slot.memwr;
    assign wb_valid_o = wb_slot.vld;
    assign wb_regwr_o = wb_slot.vld & (wb_slot.alu2reg | wb_slot.mem2reg);
    assign fd_kill_o  = kill;
    assign fwd1_sel_o = sel[0];
    assign fwd2_sel_o = sel[1];
    assign ex_op1_o   = op[0];
    assign ex_op2_o   = op[1];

    assert_x0_never_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_slot.rd == '0) |-> (sel[0] == SEL_RF && sel[1] == SEL_RF));
    assert_idle_wb_no_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_regwr_o |-> (fwd1_sel_o == 2'd0 && fwd2_sel_o == 2'd0));
    assert_killed_no_regwr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!ex_regwr_o ##1 !wb_regwr_o));
endmodule

// File: tb/hz3_ctrl_tb.sv
`timescale 1ns/1ps
module hz3_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fd_valid_i = 1'b0;
    logic [4:0] fd_rs1_i = '0, fd_rs2_i = '0, fd_rd_i = '0;
    logic fd_alu2reg_i = 1'b0, fd_mem2reg_i = 1'b0, fd_memwr_i = 1'b0;
    logic ex_taken_i = 1'b0;
    logic [31:0] rf_rs1_data_i = 32'hA1A1_0001;
    logic [31:0] rf_rs2_data_i = 32'hB2B2_0002;
    logic [31:0] wb_alu_data_i = 32'hC3C3_0003;
    logic [31:0] wb_load_data_i = 32'hD4D4_0004;
    logic ex_valid_o, ex_regwr_o, ex_memwr_o, wb_valid_o, wb_regwr_o, fd_kill_o;
    logic [1:0] fwd1_sel_o, fwd2_sel_o;
    logic [31:0] ex_op1_o, ex_op2_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hz3_ctrl u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [4:0] rs1, input logic [4:0] rs2,
                         input logic [4:0] rd, input logic a, input logic m,
                         input logic w, input logic t);
        fd_valid_i = v; fd_rs1_i = rs1; fd_rs2_i = rs2; fd_rd_i = rd;
        fd_alu2reg_i = a; fd_mem2reg_i = m; fd_memwr_i = w; ex_taken_i = t;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_op(input logic [1:0] s, input logic [31:0] rf);
        return (s == 2'd1) ? wb_alu_data_i : (s == 2'd2) ? wb_load_data_i : rf;
    endfunction

    initial begin
        repeat (3) tick();
        // R9 reset state
        chk("R9 ex_valid", ex_valid_o, 0);
        chk("R9 wb_valid", wb_valid_o, 0);
        chk("R9 kill", fd_kill_o, 0);
        chk("R9 sel1", fwd1_sel_o, 0);
        chk("R9 sel2", fwd2_sel_o, 0);
        rst_n = 1'b1;

        // R10 taken ignored while execute is empty
        drive(1, 0, 0, 0, 0, 0, 0, 1);
        #1 chk("R10 kill while ex empty", fd_kill_o, 0);
        tick();
        chk("R10 younger proceeds", ex_valid_o, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        tick(); tick();

        // Sweep: producer then consumer (R2 R3 R4 R5 R6 R1)
        for (int rd = 0; rd < 32; rd++) begin
            for (int fl = 0; fl < 4; fl++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [4:0] r1, r2;
                    logic wr;
                    logic [1:0] e1, e2;
                    string tag;
                    r1 = p[0] ? 5'(rd) : 5'(rd ^ 1);
                    r2 = p[1] ? 5'(rd) : 5'((rd + 1) % 32);
                    drive(1, 0, 0, 5'(rd), fl[0], fl[1], 0, 0);
                    tick();
                    drive(1, r1, r2, 0, 0, 0, 0, 0);
                    tick();
                    wr = (fl != 0) && (rd != 0);
                    e1 = (wr && r1 == 5'(rd)) ? (fl[1] ? 2'd2 : 2'd1) : 2'd0;
                    e2 = (wr && r2 == 5'(rd)) ? (fl[1] ? 2'd2 : 2'd1) : 2'd0;
                    if (rd == 0) tag = "R5";
                    else if (fl == 0) tag = "R6";
                    else if (fl[1]) tag = "R3";
                    else tag = "R2";
                    chk({tag, " sel1"}, fwd1_sel_o, e1);
                    chk({tag, " op1"}, ex_op1_o, exp_op(e1, rf_rs1_data_i));
                    chk({tag, " R4 sel2"}, fwd2_sel_o, e2);
                    chk({tag, " R4 op2"}, ex_op2_o, exp_op(e2, rf_rs2_data_i));
                    chk("R1 wb_valid", wb_valid_o, 1);
                end
            end
        end

        // Back-to-back ALU chain (R2 R1)
        drive(0, 0, 0, 0, 0, 0, 0, 0); tick(); tick();
        drive(1, 0, 0, 3, 1, 0, 0, 0); tick();
        chk("R1 ex after one clock", ex_valid_o, 1);
        drive(1, 3, 0, 4, 1, 0, 0, 0); tick();
        chk("R2 chain x3 sel1", fwd1_sel_o, 1);
        drive(1, 4, 4, 5, 1, 0, 0, 0); tick();
        chk("R2 chain x4 sel1", fwd1_sel_o, 1);
        chk("R4 chain x4 sel2", fwd2_sel_o, 1);

        // Load then dependent branch, taken (R3 R7 R8)
        drive(1, 0, 0, 14, 0, 1, 0, 0); tick();
        drive(1, 14, 2, 0, 0, 0, 0, 0); tick();
        chk("R3 load to branch sel1", fwd1_sel_o, 2);
        chk("R3 load to branch op1", ex_op1_o, wb_load_data_i);
        drive(1, 0, 0, 9, 1, 0, 1, 1);
        #1 chk("R7 first kill", fd_kill_o, 1);
        tick();
        chk("R8 killed not valid in ex", ex_valid_o, 0);
        chk("R8 killed regwr low", ex_regwr_o, 0);
        chk("R8 killed memwr low", ex_memwr_o, 0);
        drive(1, 0, 0, 9, 1, 0, 1, 0);
        #1 chk("R7 second kill", fd_kill_o, 1);
        tick();
        chk("R8 second killed not valid", ex_valid_o, 0);
        chk("R8 first killed not in wb", wb_valid_o, 0);
        chk("R8 first killed wb regwr", wb_regwr_o, 0);
        drive(1, 9, 9, 0, 0, 0, 0, 0);
        #1 chk("R7 no third kill", fd_kill_o, 0);
        tick();
        chk("R7 target enters ex", ex_valid_o, 1);
        chk("R8 killed dest not forwarded sel1", fwd1_sel_o, 0);
        chk("R8 killed dest not forwarded sel2", fwd2_sel_o, 0);
        chk("R8 op1 from rf", ex_op1_o, rf_rs1_data_i);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        #1 chk("R7 kill stays low", fd_kill_o, 0);
        tick();
        chk("R6 target in wb no write", fwd1_sel_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule